// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

The block takes a serial bit stream on its own shift clock and moves it through a chain of stages. A second, independent latch clock copies the whole chain in one step into a storage register, which then drives the parallel outputs. The parallel outputs can be switched to high impedance with an active-low enable. The last stage is always driven out as a serial cascade output, so several blocks can be daisy-chained and loaded like an SPI receiver: the host shifts in all bits, then pulses the latch clock once.

An active-low asynchronous reset clears the shift stages only. The storage register starts at zero at power-up and is otherwise changed only by the latch clock. A separate view of the storage register, and a flag that shows whether the parallel outputs are driven, let the surrounding logic see the stored byte while the outputs are disabled.

Top module: `latched_shift_reg`

## Requirements
- R1: On each rising edge of `shiftClk`, stage 0 takes `serIn` and each stage i takes the old value of stage i-1. Stage i is bit i of `storeView` and `parOut` once latched, so the first of eight bits shifted in ends up in bit 7.
- R2: `serOut` always shows the last stage (bit WIDTH-1). After each shift it therefore carries the value that was in the next-to-last stage, and it is never high impedance.
- R3: A low level on `rstN` clears every shift stage at once, without any clock edge.
- R4: `rstN` has no effect on the storage register; `storeView` keeps its value through a reset.
- R5: On each rising edge of `latchClk`, all shift stages are copied together into the storage register, which `storeView` shows.
- R6: While `oeN` is low, `parDrive` is 1 and `parOut` equals the storage register.
- R7: While `oeN` is high, `parDrive` is 0 and `parOut` is high impedance; `serOut` and `storeView` do not change.
- R8: Without a rising edge on `shiftClk` the shift stages hold, even if `serIn` changes. Without a rising edge on `latchClk` the storage register holds.
- R9: When both clocks rise on the same edge, the storage register takes the shift contents from before that edge.
- R10: The storage register is all zeros at power-up, before any latch edge.
- R11: With two blocks chained (`serOut` of the near block into `serIn` of the far block), 16 shifts followed by one latch edge place the first byte in the far block and the second byte in the near block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock, rising edge active |
| latchClk | input | 1 | Storage clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low clear of the shift stages |
| serIn | input | 1 | Serial data into stage 0 |
| oeN | input | 1 | Active-low enable of the parallel outputs |
| parOut | output | WIDTH | Tri-state parallel outputs from the storage register |
| parDrive | output | 1 | High while the parallel outputs are driven |
| serOut | output | 1 | Cascade output, last shift stage |
| storeView | output | WIDTH | Storage register contents, always driven |

## Verification
The assertions watch every shift edge: the stage-by-stage move of the chain, the serial tap lagging the next-to-last stage, and the enable gating of the parallel outputs against the stored value. They also check that the chain reads zero when a latch edge arrives under reset. Only the bench scenarios can show the effects that depend on stimulus order: the storage register keeping its value through a reset, holding when no latch edge comes, taking the pre-edge value when both clocks rise together, and starting at zero. The two-block cascade, where the first byte must reach the far block after sixteen shifts, is also covered only by the bench.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  // Strobes the control half hands to the datapath.
  typedef struct packed {
    logic driveEn;   // parallel outputs are driven
  } lsrStrobe_t;

endpackage

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
(
  input  logic       oeN,
  output lsrStrobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.driveEn = ~oeN;
  end

endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             rstN,
  input  logic             serIn,
  output logic [WIDTH-1:0] shiftQ,
  output logic [WIDTH-1:0] storeQ,
  output logic             serOut
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] nextChain;
  logic [WIDTH-1:0] storeReg = '0;   // power-up value, no reset

  // Next value of each stage: stage 0 from the pin, others from their neighbour.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign nextChain[i] = serIn;
      end else begin : g_body
        assign nextChain[i] = shiftQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge shiftClk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= nextChain;
  end

  always_ff @(posedge latchClk) begin
    storeReg <= shiftQ;
  end

  assign storeQ = storeReg;
  assign serOut = shiftQ[LAST];

endmodule

// File: rtl/latched_shift_reg.sv
module latched_shift_reg
  import lsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             latchClk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             oeN,
  output logic [WIDTH-1:0] parOut,
  output logic             parDrive,
  output logic             serOut,
  output logic [WIDTH-1:0] storeView
);

  lsrStrobe_t       strobe;
  logic [WIDTH-1:0] shiftQ;
  logic [WIDTH-1:0] storeQ;

  lsr_ctrl u_ctrl (
    .oeN    (oeN),
    .strobe (strobe)
  );

  lsr_datapath #(.WIDTH(WIDTH)) u_dp (
    .shiftClk (shiftClk),
    .latchClk (latchClk),
    .rstN     (rstN),
    .serIn    (serIn),
    .shiftQ   (shiftQ),
    .storeQ   (storeQ),
    .serOut   (serOut)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign parOut[i] = strobe.driveEn ? storeQ[i] : 1'bz;
    end
  endgenerate

  assign parDrive  = strobe.driveEn;
  assign storeView = storeQ;

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
  parameter int WIDTH = 8
) (
  input logic             shiftClk,
  input logic             latchClk,
  input logic             rstN,
  input logic             serIn,
  input logic             oeN,
  input logic [WIDTH-1:0] parOut,
  input logic             parDrive,
  input logic             serOut,
  input logic [WIDTH-1:0] storeView,
  input logic [WIDTH-1:0] shiftQ
);

  // Set once a shift edge has passed with no reset since.
  logic snapValid = 1'b0;
  always_ff @(posedge shiftClk or negedge rstN) begin
    if (!rstN) snapValid <= 1'b0;
    else       snapValid <= 1'b1;
  end

  p_shift_move_r1: assert property (@(posedge shiftClk) disable iff (!rstN)
    snapValid |-> shiftQ == {$past(shiftQ[WIDTH-2:0]), $past(serIn)});

  p_serial_tap_r2: assert property (@(posedge shiftClk) disable iff (!rstN)
    snapValid |-> serOut == $past(shiftQ[WIDTH-2]));

  p_disabled_r7: assert property (@(posedge shiftClk) disable iff (!rstN)
    oeN |-> !parDrive);

  p_driven_r6: assert property (@(posedge shiftClk) disable iff (!rstN)
    !oeN |-> (parDrive && parOut == storeView));

  always @(posedge latchClk) begin
    if (!rstN) begin
      a_reset_clear_r3: assert (shiftQ == '0);
    end
  end

endmodule

bind latched_shift_reg lsr_checker #(.WIDTH(WIDTH)) u_chk (
  .shiftClk  (shiftClk),
  .latchClk  (latchClk),
  .rstN      (rstN),
  .serIn     (serIn),
  .oeN       (oeN),
  .parOut    (parOut),
  .parDrive  (parDrive),
  .serOut    (serOut),
  .storeView (storeView),
  .shiftQ    (shiftQ)
);

// File: tb/tb_latched_shift_reg.sv
module tb_latched_shift_reg;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       shiftClk = 1'b0;
  logic       latchClk = 1'b0;
  logic       rstN     = 1'b0;
  logic       serIn    = 1'b0;
  logic       oeN      = 1'b1;
  logic [7:0] parOut, parOutFar, storeView, storeFar;
  logic       parDrive, parDriveFar, serOut, serOutFar;

  latched_shift_reg #(.WIDTH(8)) dut (
    .shiftClk(shiftClk), .latchClk(latchClk), .rstN(rstN), .serIn(serIn),
    .oeN(oeN), .parOut(parOut), .parDrive(parDrive), .serOut(serOut),
    .storeView(storeView)
  );

  latched_shift_reg #(.WIDTH(8)) dutFar (
    .shiftClk(shiftClk), .latchClk(latchClk), .rstN(rstN), .serIn(serOut),
    .oeN(oeN), .parOut(parOutFar), .parDrive(parDriveFar), .serOut(serOutFar),
    .storeView(storeFar)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the shift chain and storage of the near block.
  logic [7:0] expShift = 8'h00;
  logic [7:0] expStore = 8'h00;

  // Vectors: {oeN, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h01}, {1'b1, 8'h80},
    {1'b0, 8'hFF}, {1'b1, 8'h00}, {1'b0, 8'h6C}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b;
    @(posedge clk); shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    expShift = {expShift[6:0], b};
  endtask

  task automatic latchPulse();
    @(posedge clk); latchClk = 1'b1;
    @(negedge clk); latchClk = 1'b0;
    expStore = expShift;
  endtask

  task automatic shiftByte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic prevTop;
      prevTop = expShift[6];
      shiftBit(d[i]);
      check("R2 serOut after shift", {7'd0, serOut}, {7'd0, prevTop});
    end
  endtask

  initial begin
    // R10: power-up storage value, outputs disabled
    #1;
    check("R10 storage at power-up", storeView, 8'h00);
    check("R7 parDrive with oeN high", {7'd0, parDrive}, 8'h00);
    #8 rstN = 1'b1;

    // Table walk: R1, R2, R5, R6, R7
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      d = VEC[v][7:0];
      oeN = VEC[v][8];
      shiftByte(d);
      check("R1 serOut is first bit of byte", {7'd0, serOut}, {7'd0, d[7]});
      latchPulse();
      check("R5 storage after latch", storeView, d);
      if (!oeN) begin
        check("R6 parOut driven", parOut, d);
        check("R6 parDrive", {7'd0, parDrive}, 8'h01);
      end else begin
        check("R7 parDrive off", {7'd0, parDrive}, 8'h00);
        check("R7 serOut unaffected", {7'd0, serOut}, {7'd0, d[7]});
      end
    end

    // R8: serIn wiggles without clocks, latch without new shifts
    oeN = 1'b0;
    shiftByte(8'h96);
    latchPulse();
    @(negedge clk); serIn = ~serIn;
    @(negedge clk); serIn = ~serIn;
    check("R8 serOut holds without shift edge", {7'd0, serOut}, 8'h01);
    check("R8 storage holds without latch edge", storeView, 8'h96);
    latchPulse();
    check("R8 storage re-latch same chain", storeView, 8'h96);

    // R9: both clocks on the same edge
    @(negedge clk); serIn = 1'b1;
    @(posedge clk); shiftClk = 1'b1; latchClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0; latchClk = 1'b0;
    expStore = expShift;
    expShift = {expShift[6:0], 1'b1};
    check("R9 storage takes pre-edge chain", storeView, 8'h96);
    latchPulse();
    check("R9 later latch sees shifted chain", storeView, 8'h2D);

    // R3 / R4: async reset between clock edges
    shiftByte(8'h3C);
    check("R4 storage before reset", storeView, 8'h2D);
    #1 rstN = 1'b0;
    #1;
    check("R3 serOut cleared without clock", {7'd0, serOut}, 8'h00);
    check("R4 storage kept through reset", storeView, 8'h2D);
    check("R6 parOut kept through reset", parOut, 8'h2D);
    #3 rstN = 1'b1;
    expShift = 8'h00;
    latchPulse();
    check("R3 cleared chain latched", storeView, 8'h00);

    // R11: two blocks chained, 16 shifts then one latch
    shiftByte(8'hC3);
    shiftByte(8'h5A);
    latchPulse();
    check("R11 far block holds first byte", storeFar, 8'hC3);
    check("R11 far parOut", parOutFar, 8'hC3);
    check("R11 near block holds second byte", storeView, 8'h5A);
    check("R11 far cascade output", {7'd0, serOutFar}, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule